// File: doc/BRIEF.md
# SD SPI Data Block Transfer Engine

This block moves whole 512-byte data blocks between a local byte buffer and a memory card in SPI mode. A request names a direction, a starting block number and a block count. For each block, the engine asks a separate command layer to issue a single-block read or write command. If that command succeeds, the engine drives the data phase one byte exchange at a time. The exchanges go through a byte-level SPI engine, which is not part of this block.

On a read, the engine hunts for the start token, stores the payload in the buffer, throws away the two checksum bytes and closes the transfer. On a write, it sends the start token, the payload and two filler checksum bytes. It then checks the card's data-response token and waits while the card signals busy.

Every wait on the card is bounded by a poll limit, so a silent card produces a timeout code instead of a hang. The request ends after the requested number of blocks, or earlier at the first error. Completion is shown by a single-cycle pulse that carries the result code.

Top module: `sd_blk_xfer`

## Requirements
- R1: The command argument for each block is the block number shifted left by 9 (multiplied by 512) when `hc_card` is 0, and the block number unchanged when `hc_card` is 1. Consecutive blocks of one request use consecutive block numbers, starting at `start_blk`.
- R2: A read request issues command index 17 and a write request issues index 24. A non-zero `cmd_r1` ends the request with `err` = 1, with no data exchange and no further command.
- R3: On a read, with `cs_n` low, the engine sends 0xFF until it receives 0xFE. It then captures exactly 512 received bytes in order, at buffer address (block offset within the request) * 512 + byte index.
- R4: After the read payload, two more 0xFF exchanges are made with `cs_n` low. Then one 0xFF exchange is made with `cs_n` high, which closes the block.
- R5: On a write, the engine sends 0xFE, then the 512 buffer bytes in address order, then two 0xFF bytes, all with `cs_n` low.
- R6: After the write checksum bytes, one 0xFF exchange returns the data-response token. If its low five bits are 00101, the write is accepted. Any other value (for example status 101 for a checksum error, or 110 for a write error) ends the request with `err` = 2, after one closing 0xFF exchange with `cs_n` high.
- R7: After an accepted token, the engine keeps sending 0xFF while the card returns 0x00. The first non-zero byte ends the busy wait, and the closing 0xFF exchange with `cs_n` high follows.
- R8: A request of N blocks runs N block transfers back to back, with buffer offsets advancing by 512 bytes per block. A count of 0 completes at once with `err` = 0 and no traffic.
- R9: When the start-token hunt or the busy wait gets POLL_LIMIT unsuccessful bytes in a row, the request ends with `err` = 3, after the closing 0xFF exchange with `cs_n` high. A success on the last allowed poll still counts as a success.
- R10: `done` is a one-cycle pulse that marks the end of each request, with `err` valid in that cycle. `busy` is high from acceptance until completion. `cs_n` is high whenever the engine is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accept a request while idle |
| wr_mode | input | 1 | 1 = write to card, 0 = read from card |
| hc_card | input | 1 | 1 = block-addressed card, 0 = byte-addressed card |
| start_blk | input | ADDR_W | First block number |
| blk_count | input | CNT_W | Number of blocks |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | 0 ok, 1 command rejected, 2 token rejected, 3 timeout |
| cmd_req | output | 1 | One-cycle pulse asking the command layer to issue a command |
| cmd_idx | output | 6 | Command index |
| cmd_arg | output | ADDR_W | Command argument |
| cmd_done | input | 1 | Command layer finished; `cmd_r1` valid |
| cmd_r1 | input | 8 | R1 status byte of the command |
| cs_n | output | 1 | Card chip-select for the data phase, active low |
| xch_req | output | 1 | One-cycle pulse starting a byte exchange |
| xch_tx | output | 8 | Byte to send, valid with `xch_req` |
| xch_done | input | 1 | Exchange finished; `xch_rx` valid |
| xch_rx | input | 8 | Byte received |
| buf_addr | output | BUF_AW | Buffer byte address |
| buf_re | output | 1 | Buffer read strobe; data appears one cycle later |
| buf_we | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Buffer write data |
| buf_rdata | input | 8 | Buffer read data |

## Verification
Two events can land on the same received byte: the poll watchdog reaching its limit, and the byte the engine is waiting for (the 0xFE start token, or the first non-zero byte after busy). The bench provokes this in two ways. It makes the card send 0xFE exactly on the POLL_LIMIT-th hunt poll, and it makes the card end busy exactly on the POLL_LIMIT-th busy poll. Both cases must finish with `err` = 0 and the full expected byte stream. In contrast, one more failed poll in each wait must give `err` = 3, followed by the single closing exchange with `cs_n` high.

// File: rtl/sd_xfer_pkg.sv
package sd_xfer_pkg;

   typedef enum logic [1:0] {
      XE_OK      = 2'd0,
      XE_CMD     = 2'd1,
      XE_TOKEN   = 2'd2,
      XE_TIMEOUT = 2'd3
   } xfer_err_e;

   typedef enum logic [3:0] {
      S_IDLE,
      S_CMD,
      S_CMD_WAIT,
      S_R_HUNT,
      S_R_DATA,
      S_R_CRC,
      S_W_TOK,
      S_W_FETCH,
      S_W_DATA,
      S_W_CRC,
      S_W_RESP,
      S_W_BUSY,
      S_TAIL
   } xfer_state_e;

   localparam logic [5:0] CMD_IDX_RD = 6'd17;
   localparam logic [5:0] CMD_IDX_WR = 6'd24;
   localparam logic [7:0] TOK_START  = 8'hFE;
   localparam logic [7:0] FILL_BYTE  = 8'hFF;
   localparam logic [4:0] RESP_ACCEPT = 5'b00101;

endpackage

// File: rtl/sd_addr_scale.sv
module sd_addr_scale #(
   parameter int ADDR_W     = 32,
   parameter int SHIFT      = 9,
   parameter bit HC_SUPPORT = 1'b1
) (
   input  logic [ADDR_W-1:0] blk,
   input  logic              hc,
   output logic [ADDR_W-1:0] arg
);

   generate
      if (SHIFT < 1 || SHIFT >= ADDR_W) begin : g_bad_shift
         $error("sd_addr_scale: SHIFT out of range");
      end
      if (HC_SUPPORT) begin : g_dual
         // card type picks byte or block addressing at run time
         assign arg = hc ? blk : (blk << SHIFT);
      end else begin : g_byte_only
         logic unused_hc;
         assign unused_hc = hc;
         assign arg = blk << SHIFT;
      end
   endgenerate

endmodule

// File: rtl/sd_poll_wdog.sv
module sd_poll_wdog #(
   parameter int LIMIT = 4096,
   localparam int CW   = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic miss,
   output logic expire
);

   logic [CW-1:0] cnt;

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("sd_poll_wdog: LIMIT must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (clr)    cnt <= '0;
      else if (miss)   cnt <= cnt + 1'b1;
   end

   // the limit-th consecutive miss expires; a hit on that poll does not
   assign expire = miss && (cnt == CW'(LIMIT - 1));

   AST_WD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> clr); // R9

endmodule

// File: rtl/sd_blk_xfer.sv
module sd_blk_xfer
   import sd_xfer_pkg::*;
#(
   parameter int BLK_BYTES  = 512,
   parameter int CNT_W      = 8,
   parameter int ADDR_W     = 32,
   parameter int POLL_LIMIT = 4096,
   parameter bit HC_SUPPORT = 1'b1,
   parameter int BUF_AW     = CNT_W + $clog2(BLK_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              wr_mode,
   input  logic              hc_card,
   input  logic [ADDR_W-1:0] start_blk,
   input  logic [CNT_W-1:0]  blk_count,
   output logic              busy,
   output logic              done,
   output logic [1:0]        err,
   output logic              cmd_req,
   output logic [5:0]        cmd_idx,
   output logic [ADDR_W-1:0] cmd_arg,
   input  logic              cmd_done,
   input  logic [7:0]        cmd_r1,
   output logic              cs_n,
   output logic              xch_req,
   output logic [7:0]        xch_tx,
   input  logic              xch_done,
   input  logic [7:0]        xch_rx,
   output logic [BUF_AW-1:0] buf_addr,
   output logic              buf_re,
   output logic              buf_we,
   output logic [7:0]        buf_wdata,
   input  logic [7:0]        buf_rdata
);

   localparam int BYTE_W = $clog2(BLK_BYTES);
   localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(BLK_BYTES - 1);

   generate
      if ((1 << BYTE_W) != BLK_BYTES) begin : g_bad_blk
         $error("sd_blk_xfer: BLK_BYTES must be a power of two");
      end
      if (BUF_AW < CNT_W + BYTE_W) begin : g_bad_buf
         $error("sd_blk_xfer: BUF_AW too narrow");
      end
   endgenerate

   xfer_state_e       state;
   logic              pend, got, crc2, wr_r, hc_r, done_r;
   logic [BYTE_W-1:0] cnt;
   logic [ADDR_W-1:0] blk_cur;
   logic [CNT_W-1:0]  blk_off, blk_left;
   xfer_err_e         err_r, tail_err;
   logic              poll_state, poll_miss, poll_expire, byte_state;

   sd_addr_scale #(.ADDR_W(ADDR_W), .SHIFT(BYTE_W), .HC_SUPPORT(HC_SUPPORT)) u_scale (
      .blk (blk_cur),
      .hc  (hc_r),
      .arg (cmd_arg)
   );

   assign poll_state = (state == S_R_HUNT) || (state == S_W_BUSY);
   assign poll_miss  = got && (((state == S_R_HUNT) && (xch_rx != TOK_START)) ||
                               ((state == S_W_BUSY) && (xch_rx == 8'h00)));

   sd_poll_wdog #(.LIMIT(POLL_LIMIT)) u_wdog (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (!poll_state),
      .miss   (poll_miss),
      .expire (poll_expire)
   );

   always_comb begin
      byte_state = 1'b0;
      case (state)
         S_R_HUNT, S_R_DATA, S_R_CRC, S_W_TOK, S_W_DATA,
         S_W_CRC, S_W_RESP, S_W_BUSY, S_TAIL: byte_state = 1'b1;
         default: byte_state = 1'b0;
      endcase
   end

   always_comb begin
      case (state)
         S_W_TOK:  xch_tx = TOK_START;
         S_W_DATA: xch_tx = buf_rdata;
         default:  xch_tx = FILL_BYTE;
      endcase
   end

   assign got       = pend && xch_done;
   assign xch_req   = byte_state && !pend;
   assign cs_n      = (state == S_IDLE) || (state == S_CMD) ||
                      (state == S_CMD_WAIT) || (state == S_TAIL);
   assign busy      = (state != S_IDLE);
   assign done      = done_r;
   assign err       = err_r;
   assign cmd_req   = (state == S_CMD);
   assign cmd_idx   = wr_r ? CMD_IDX_WR : CMD_IDX_RD;
   assign buf_addr  = BUF_AW'({blk_off, cnt});
   assign buf_re    = (state == S_W_FETCH);
   assign buf_we    = got && (state == S_R_DATA);
   assign buf_wdata = xch_rx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         pend     <= 1'b0;
         cnt      <= '0;
         crc2     <= 1'b0;
         blk_cur  <= '0;
         blk_off  <= '0;
         blk_left <= '0;
         wr_r     <= 1'b0;
         hc_r     <= 1'b0;
         err_r    <= XE_OK;
         tail_err <= XE_OK;
         done_r   <= 1'b0;
      end else begin
         done_r <= 1'b0;
         if (xch_req)  pend <= 1'b1;
         else if (got) pend <= 1'b0;
         case (state)
            S_IDLE: if (start) begin
               if (blk_count == '0) begin
                  done_r <= 1'b1;
                  err_r  <= XE_OK;
               end else begin
                  wr_r     <= wr_mode;
                  hc_r     <= hc_card;
                  blk_cur  <= start_blk;
                  blk_off  <= '0;
                  blk_left <= blk_count;
                  state    <= S_CMD;
               end
            end
            S_CMD: begin
               tail_err <= XE_OK;
               state    <= S_CMD_WAIT;
            end
            S_CMD_WAIT: if (cmd_done) begin
               if (cmd_r1 != 8'h00) begin
                  state  <= S_IDLE;
                  done_r <= 1'b1;
                  err_r  <= XE_CMD;
               end else begin
                  state <= wr_r ? S_W_TOK : S_R_HUNT;
               end
            end
            S_R_HUNT: if (got) begin
               if (xch_rx == TOK_START) begin
                  cnt   <= '0;
                  state <= S_R_DATA;
               end else if (poll_expire) begin
                  tail_err <= XE_TIMEOUT;
                  state    <= S_TAIL;
               end
            end
            S_R_DATA: if (got) begin
               if (cnt == LAST_BYTE) begin
                  crc2  <= 1'b0;
                  state <= S_R_CRC;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            S_R_CRC: if (got) begin
               crc2 <= 1'b1;
               if (crc2) state <= S_TAIL;
            end
            S_W_TOK: if (got) begin
               cnt   <= '0;
               state <= S_W_FETCH;
            end
            S_W_FETCH: state <= S_W_DATA;
            S_W_DATA: if (got) begin
               if (cnt == LAST_BYTE) begin
                  crc2  <= 1'b0;
                  state <= S_W_CRC;
               end else begin
                  cnt   <= cnt + 1'b1;
                  state <= S_W_FETCH;
               end
            end
            S_W_CRC: if (got) begin
               crc2 <= 1'b1;
               if (crc2) state <= S_W_RESP;
            end
            S_W_RESP: if (got) begin
               if (xch_rx[4:0] == RESP_ACCEPT) begin
                  state <= S_W_BUSY;
               end else begin
                  tail_err <= XE_TOKEN;
                  state    <= S_TAIL;
               end
            end
            S_W_BUSY: if (got) begin
               if (xch_rx != 8'h00) begin
                  state <= S_TAIL;
               end else if (poll_expire) begin
                  tail_err <= XE_TIMEOUT;
                  state    <= S_TAIL;
               end
            end
            S_TAIL: if (got) begin
               if (tail_err != XE_OK || blk_left == CNT_W'(1)) begin
                  state  <= S_IDLE;
                  done_r <= 1'b1;
                  err_r  <= tail_err;
               end else begin
                  blk_cur  <= blk_cur + 1'b1;
                  blk_off  <= blk_off + 1'b1;
                  blk_left <= blk_left - 1'b1;
                  state    <= S_CMD;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
   AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> cs_n); // R10
   AST_CMD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req |-> (cmd_idx == CMD_IDX_RD || cmd_idx == CMD_IDX_WR)); // R2
   AST_STORE_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> !cs_n); // R3
   AST_TOKEN_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (xch_req && xch_tx == TOK_START && wr_r) |-> !cs_n); // R5

endmodule

// File: tb/sim_sd_blk_xfer.sv
module sim_sd_blk_xfer;

   localparam int CW  = 8;
   localparam int AW  = 32;
   localparam int LIM = 16;
   localparam int BAW = CW + 9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, wr_mode = 1'b0, hc_card = 1'b0;
   logic [AW-1:0] start_blk = '0;
   logic [CW-1:0] blk_count = '0;
   logic busy, done;
   logic [1:0] err;
   logic cmd_req;
   logic [5:0] cmd_idx;
   logic [AW-1:0] cmd_arg;
   logic cmd_done = 1'b0;
   logic [7:0] cmd_r1 = 8'h00;
   logic cs_n, xch_req;
   logic [7:0] xch_tx;
   logic xch_done = 1'b0;
   logic [7:0] xch_rx = 8'h00;
   logic [BAW-1:0] buf_addr;
   logic buf_re, buf_we;
   logic [7:0] buf_wdata;
   logic [7:0] buf_rdata = 8'h00;

   int checks = 0;
   int fails = 0;

   logic [8:0]  xq[$];   // {cs_n, tx} expected per exchange
   logic [7:0]  rq[$];   // card reply per exchange
   logic [37:0] cq[$];   // {idx, arg} expected per command
   logic [7:0]  r1q[$];  // R1 reply per command
   logic [7:0]  mem [0:2047];
   logic [7:0]  r_x, r_c;
   logic [8:0]  e_x;
   logic [37:0] e_c;

   always #5 clk = ~clk;

   sd_blk_xfer #(.POLL_LIMIT(LIM)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .wr_mode(wr_mode), .hc_card(hc_card),
      .start_blk(start_blk), .blk_count(blk_count), .busy(busy), .done(done), .err(err),
      .cmd_req(cmd_req), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .cmd_done(cmd_done),
      .cmd_r1(cmd_r1), .cs_n(cs_n), .xch_req(xch_req), .xch_tx(xch_tx),
      .xch_done(xch_done), .xch_rx(xch_rx), .buf_addr(buf_addr), .buf_re(buf_re),
      .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata)
   );

   // buffer model: one-cycle read latency
   always @(posedge clk) begin
      if (buf_we) mem[buf_addr[10:0]] <= buf_wdata;
      if (buf_re) buf_rdata <= mem[buf_addr[10:0]];
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // monitor: pops scoreboard items as the design produces traffic
   initial forever begin
      @(negedge clk);
      if (xch_req) begin
         if (xq.size() == 0) chk(1'b0, "R3/R5", "unexpected exchange", {cs_n, xch_tx}, 0);
         else begin
            e_x = xq.pop_front();
            chk({cs_n, xch_tx} == e_x, "R3/R4/R5/R6/R7", "exchange {cs_n,tx}", {cs_n, xch_tx}, e_x);
         end
      end
      if (cmd_req) begin
         if (cq.size() == 0) chk(1'b0, "R2", "unexpected command", {cmd_idx, cmd_arg}, 0);
         else begin
            e_c = cq.pop_front();
            chk({cmd_idx, cmd_arg} == e_c, "R1/R2", "command {idx,arg}", {cmd_idx, cmd_arg}, e_c);
         end
      end
   end

   // card byte responder
   initial begin
      @(negedge clk);
      forever begin
         if (xch_req) begin
            r_x = (rq.size() != 0) ? rq.pop_front() : 8'hFF;
            @(negedge clk);
            @(negedge clk);
            xch_done = 1'b1;
            xch_rx   = r_x;
            @(negedge clk);
            xch_done = 1'b0;
         end else @(negedge clk);
      end
   end

   // command layer responder
   initial begin
      @(negedge clk);
      forever begin
         if (cmd_req) begin
            r_c = (r1q.size() != 0) ? r1q.pop_front() : 8'h00;
            @(negedge clk);
            @(negedge clk);
            cmd_done = 1'b1;
            cmd_r1   = r_c;
            @(negedge clk);
            cmd_done = 1'b0;
         end else @(negedge clk);
      end
   end

   function automatic logic [7:0] rpat(int off, int i);
      return 8'((off * 37 + i * 5 + 3) & 255);
   endfunction

   function automatic logic [7:0] wpat(int off, int i);
      return 8'((off * 11 + i * 3 + 1) & 255);
   endfunction

   task automatic px(input bit cs, input logic [7:0] tx, input logic [7:0] rx);
      xq.push_back({cs, tx});
      rq.push_back(rx);
   endtask

   task automatic pc(input logic [5:0] idx, input int arg, input logic [7:0] r1);
      cq.push_back({idx, 32'(arg)});
      r1q.push_back(r1);
   endtask

   // R3 R4: expected read block traffic
   task automatic exp_read(input int arg, input int nff, input int off);
      pc(6'd17, arg, 8'h00);
      for (int k = 0; k < nff; k++) px(1'b0, 8'hFF, 8'hFF);
      px(1'b0, 8'hFF, 8'hFE);
      for (int i = 0; i < 512; i++) px(1'b0, 8'hFF, rpat(off, i));
      px(1'b0, 8'hFF, 8'hFF);
      px(1'b0, 8'hFF, 8'hFF);
      px(1'b1, 8'hFF, 8'hFF);
   endtask

   // R5 R6 R7: expected write block traffic up to the busy wait
   task automatic exp_write_head(input int arg, input int off, input logic [7:0] resp);
      pc(6'd24, arg, 8'h00);
      for (int i = 0; i < 512; i++) mem[off * 512 + i] = wpat(off, i);
      px(1'b0, 8'hFE, 8'hFF);
      for (int i = 0; i < 512; i++) px(1'b0, wpat(off, i), 8'hFF);
      px(1'b0, 8'hFF, 8'hFF);
      px(1'b0, 8'hFF, 8'hFF);
      px(1'b0, 8'hFF, resp);
   endtask

   task automatic busy_then(input int nzero, input logic [7:0] last, input bit ends);
      for (int k = 0; k < nzero; k++) px(1'b0, 8'hFF, 8'h00);
      if (ends) px(1'b0, 8'hFF, last);
      px(1'b1, 8'hFF, 8'hFF);
   endtask

   task automatic run(input bit wr, input bit hc, input int blk, input int cnt,
                      input logic [1:0] exp_err, input string req);
      @(negedge clk);
      wr_mode = wr; hc_card = hc; start_blk = AW'(blk); blk_count = CW'(cnt);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      chk(err == exp_err, req, "result code", err, exp_err);
      chk(busy == 1'b0, "R10", "busy low at done", busy, 0);
      @(negedge clk);
      chk(done == 1'b0, "R10", "done single pulse", done, 0);
      chk(xq.size() == 0 && cq.size() == 0, req, "all expected traffic seen",
          xq.size() + cq.size(), 0);
      chk(cs_n == 1'b1, "R10", "cs_n high when idle", cs_n, 1);
      xq.delete(); rq.delete(); cq.delete(); r1q.delete();
   endtask

   task automatic check_read_mem(input int off, input string req);
      int bad;
      bad = 0;
      for (int i = 0; i < 512; i++) if (mem[off * 512 + i] !== rpat(off, i)) bad++;
      chk(bad == 0, req, "read payload bytes wrong", bad, 0);
   endtask

   task automatic summary;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      chk(!busy && cs_n && !done && !xch_req && !cmd_req, "R10", "reset state",
          {busy, cs_n, done, xch_req, cmd_req}, 5'b01000);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 R3 R4 R8: two-block read, byte addressing
      exp_read(5 * 512, 3, 0);
      exp_read(6 * 512, 0, 1);
      run(1'b0, 1'b0, 5, 2, 2'd0, "R8");
      check_read_mem(0, "R3");
      check_read_mem(1, "R3");

      // R1 R5 R7 R8: two-block write, block addressing
      exp_write_head(9, 0, 8'hE5);
      busy_then(2, 8'hFF, 1'b1);
      exp_write_head(10, 1, 8'h05);
      busy_then(0, 8'h7F, 1'b1);
      run(1'b1, 1'b1, 9, 2, 2'd0, "R5");

      // R6: rejected data-response (checksum error status) stops the request
      exp_write_head(512, 0, 8'h0B);
      px(1'b1, 8'hFF, 8'hFF);
      run(1'b1, 1'b0, 1, 2, 2'd2, "R6");

      // R6: write-error status also rejected
      exp_write_head(7, 0, 8'hED);
      px(1'b1, 8'hFF, 8'hFF);
      run(1'b1, 1'b1, 7, 1, 2'd2, "R6");

      // R2: non-zero R1 aborts with no data traffic
      pc(6'd17, 4 * 512, 8'h04);
      run(1'b0, 1'b0, 4, 3, 2'd1, "R2");

      // R8: zero count completes at once
      run(1'b0, 1'b0, 0, 0, 2'd0, "R8");

      // R9: start token on the last allowed poll still succeeds
      exp_read(3, LIM - 1, 0);
      run(1'b0, 1'b1, 3, 1, 2'd0, "R9");
      check_read_mem(0, "R9");

      // R9: hunt exhausts the limit
      pc(6'd17, 2, 8'h00);
      for (int k = 0; k < LIM; k++) px(1'b0, 8'hFF, 8'hFF);
      px(1'b1, 8'hFF, 8'hFF);
      run(1'b0, 1'b1, 2, 1, 2'd3, "R9");

      // R9 R7: busy ends on the last allowed poll
      exp_write_head(11, 0, 8'h05);
      busy_then(LIM - 1, 8'h01, 1'b1);
      run(1'b1, 1'b1, 11, 1, 2'd0, "R9");

      // R9: busy never ends
      exp_write_head(12, 0, 8'h05);
      busy_then(LIM, 8'h00, 1'b0);
      run(1'b1, 1'b1, 12, 1, 2'd3, "R9");

      summary();
      $finish;
   end

endmodule